// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block waits for a program or erase operation in a parallel NOR-style flash to finish. It does not issue the command sequence. A start pulse arms it with one address inside the byte or sector being worked on. The poller then reads that address over and over through a simple synchronous read port. It judges completion from the status bits that the flash returns in each data byte.

Completion is detected when bit 6 holds the same value on two consecutive reads. If bit 6 flips and the flash also reports its own internal timeout on bit 5, one confirming read is taken before the poller gives up. A synchronised active-low ready/busy input can end polling early. A programmable read budget stops a poll that never settles. The result is reported as a one-cycle done pulse together with pass, fail, timeout and watchdog flags. These flags are held until the next accepted start.

Top module: `flash_status_poller`

## Requirements
- R1: After reset the block is idle: `busy`, `memReq` and `donePulse` are 0, and all four result flags are 0.
- R2: A start pulse while idle captures `targetAddr`. Every read of that poll uses the captured address. A start pulse while busy is ignored: no restart, no change of address and no extra done pulse.
- R3: A read is a handshake. `memReq` stays high with a stable `memAddr` until a cycle in which `memValid` is also high. `memRdata` is taken in that cycle, and only one read is outstanding at a time.
- R4: Reads come in pairs. If bit 6 of the second read equals bit 6 of the first read, the poll ends with `passFlag`.
- R5: If bit 6 differs between the pair and bit 5 of the second read is 0, a fresh pair of reads begins.
- R6: If bit 6 differs and bit 5 of the second read is 1, one confirming read is made. If its bit 6 equals that of the second read, the poll ends with `passFlag`.
- R7: If the confirming read's bit 6 still differs, the poll ends with `failFlag` and `timeoutFlag` set.
- R8: When `useRdyPin` is 1 and the synchronised `rdyBusyN` reads 1 at the completion of any read, the poll ends with `passFlag` at that read. When `useRdyPin` is 0, `rdyBusyN` has no effect.
- R9: If the count of completed reads reaches `pollLimit` and that read did not decide the result, the poll ends with `failFlag` and `wdogFlag` set. A bit-based pass or fail made on the same read wins over the watchdog.
- R10: `donePulse` lasts exactly one cycle and `busy` is low in the next cycle. The flags become valid with `donePulse`, stay unchanged until the next accepted start, and are cleared by that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin polling (accepted only when idle) |
| targetAddr | input | ADDR_W | Address inside the location under operation |
| useRdyPin | input | 1 | Let the ready/busy input end polling |
| rdyBusyN | input | 1 | Asynchronous ready (1) / busy (0) input |
| pollLimit | input | LIMIT_W | Maximum number of reads per poll |
| memReq | output | 1 | Read request |
| memAddr | output | ADDR_W | Read address |
| memRdata | input | 8 | Read data byte |
| memValid | input | 1 | Read data valid, completes the request |
| donePulse | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Poll in progress |
| passFlag | output | 1 | Operation completed |
| failFlag | output | 1 | Operation failed |
| timeoutFlag | output | 1 | Failure reported by the flash's own timeout bit |
| wdogFlag | output | 1 | Failure caused by the read budget |

## Verification
The bench targets the confirming read. A design that skips it fails at once on a single flip with bit 5 set. A design that compares the confirming read against the wrong earlier read reverses the pass/fail verdict. It also targets the read at which the budget runs out, where a design that checks the watchdog first throws away a settled result, or one that checks it late takes an extra read. The bench also starts the block again while it is busy with a slow responder: a design that restarts moves the address mid-poll or pulses done twice. Finally, it holds the ready input high with the pin disabled, so any leak of that input shortens the read count.

// File: rtl/poller_pkg.sv
package poller_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FIRST,
    ST_RD_SECOND,
    ST_RD_CONFIRM,
    ST_DONE
  } pollState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capAddr;     // capture start address
    logic clrAll;      // clear count and result flags
    logic latchByte;   // a read completed this cycle
    logic setPass;
    logic setFail;
    logic setTimeout;
    logic setWdog;
  } pollStrobe_t;

endpackage

// File: rtl/poller_datapath.sv
module poller_datapath
  import poller_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LIMIT_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pollStrobe_t        stb,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic               useRdyPin,
  input  logic               rdyBusyN,
  input  logic [LIMIT_W-1:0] pollLimit,
  input  logic               toggleBit,
  input  logic               errBitIn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               toggled,
  output logic               errBit,
  output logic               limitHit,
  output logic               rdyDone,
  output logic               passFlag,
  output logic               failFlag,
  output logic               timeoutFlag,
  output logic               wdogFlag
);

  localparam int CNT_W = LIMIT_W + 1;

  logic [ADDR_W-1:0]      addrReg;
  logic                   prevToggle;
  logic [LIMIT_W-1:0]     readCount;
  logic [SYNC_STAGES-1:0] syncReg;

  generate
    if (SYNC_STAGES == 1) begin : g_syncOne
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= rdyBusyN;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rdyBusyN};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      prevToggle <= 1'b0;
      readCount  <= '0;
    end else begin
      if (stb.capAddr) addrReg <= startAddr;
      if (stb.clrAll) readCount <= '0;
      else if (stb.latchByte) readCount <= readCount + 1'b1;
      if (stb.latchByte) prevToggle <= toggleBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll) begin
      passFlag    <= 1'b0;
      failFlag    <= 1'b0;
      timeoutFlag <= 1'b0;
      wdogFlag    <= 1'b0;
    end else begin
      if (stb.setPass)    passFlag    <= 1'b1;
      if (stb.setFail)    failFlag    <= 1'b1;
      if (stb.setTimeout) timeoutFlag <= 1'b1;
      if (stb.setWdog)    wdogFlag    <= 1'b1;
    end
  end

  assign memAddr  = addrReg;
  assign toggled  = toggleBit ^ prevToggle;
  assign errBit   = errBitIn;
  assign limitHit = (CNT_W'(readCount) + CNT_W'(1)) >= CNT_W'(pollLimit);
  assign rdyDone  = useRdyPin & syncReg[SYNC_STAGES-1];

  a_r4_pass_fail_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(passFlag && failFlag));
  a_r7_timeout_is_fail: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> failFlag);
  a_r9_wdog_is_fail: assert property (@(posedge clk) disable iff (!rstN)
    wdogFlag |-> failFlag);
  a_r9_one_cause: assert property (@(posedge clk) disable iff (!rstN)
    !(wdogFlag && timeoutFlag));

endmodule

// File: rtl/poller_ctrl.sv
module poller_ctrl
  import poller_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        memValid,
  input  logic        toggled,
  input  logic        errBit,
  input  logic        limitHit,
  input  logic        rdyDone,
  output pollStrobe_t stb,
  output logic        memReq,
  output logic        donePulse,
  output logic        busy
);

  pollState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign memReq    = (state == ST_RD_FIRST) || (state == ST_RD_SECOND) ||
                     (state == ST_RD_CONFIRM);
  assign donePulse = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          stb.capAddr = 1'b1;
          stb.clrAll  = 1'b1;
          nextState   = ST_RD_FIRST;
        end
      end
      ST_RD_FIRST: begin
        if (memValid) begin
          stb.latchByte = 1'b1;
          if (rdyDone) begin
            stb.setPass = 1'b1;
            nextState   = ST_DONE;
          end else if (limitHit) begin
            stb.setFail = 1'b1;
            stb.setWdog = 1'b1;
            nextState   = ST_DONE;
          end else begin
            nextState = ST_RD_SECOND;
          end
        end
      end
      ST_RD_SECOND: begin
        if (memValid) begin
          stb.latchByte = 1'b1;
          if (rdyDone || !toggled) begin
            stb.setPass = 1'b1;
            nextState   = ST_DONE;
          end else if (limitHit) begin
            stb.setFail = 1'b1;
            stb.setWdog = 1'b1;
            nextState   = ST_DONE;
          end else if (errBit) begin
            nextState = ST_RD_CONFIRM;
          end else begin
            nextState = ST_RD_FIRST;
          end
        end
      end
      ST_RD_CONFIRM: begin
        if (memValid) begin
          stb.latchByte = 1'b1;
          nextState     = ST_DONE;
          if (rdyDone || !toggled) begin
            stb.setPass = 1'b1;
          end else begin
            stb.setFail    = 1'b1;
            stb.setTimeout = 1'b1;
          end
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> memReq);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !busy);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);
  a_r2_busy_start_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && startPulse) |=> !stb.capAddr);

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import poller_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LIMIT_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TOGGLE_BIT  = 6,
  parameter int ERR_BIT     = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [ADDR_W-1:0]  targetAddr,
  input  logic               useRdyPin,
  input  logic               rdyBusyN,
  input  logic [LIMIT_W-1:0] pollLimit,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [7:0]         memRdata,
  input  logic               memValid,
  output logic               donePulse,
  output logic               busy,
  output logic               passFlag,
  output logic               failFlag,
  output logic               timeoutFlag,
  output logic               wdogFlag
);

  pollStrobe_t stb;
  logic toggled, errBit, limitHit, rdyDone;

  poller_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .memValid   (memValid),
    .toggled    (toggled),
    .errBit     (errBit),
    .limitHit   (limitHit),
    .rdyDone    (rdyDone),
    .stb        (stb),
    .memReq     (memReq),
    .donePulse  (donePulse),
    .busy       (busy)
  );

  poller_datapath #(
    .ADDR_W      (ADDR_W),
    .LIMIT_W     (LIMIT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .startAddr   (targetAddr),
    .useRdyPin   (useRdyPin),
    .rdyBusyN    (rdyBusyN),
    .pollLimit   (pollLimit),
    .toggleBit   (memRdata[TOGGLE_BIT]),
    .errBitIn    (memRdata[ERR_BIT]),
    .memAddr     (memAddr),
    .toggled     (toggled),
    .errBit      (errBit),
    .limitHit    (limitHit),
    .rdyDone     (rdyDone),
    .passFlag    (passFlag),
    .failFlag    (failFlag),
    .timeoutFlag (timeoutFlag),
    .wdogFlag    (wdogFlag)
  );

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> $stable(memAddr));
  a_r10_flags_need_done: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(passFlag) || $rose(failFlag)) |-> donePulse);

endmodule

// File: tb/flash_status_poller_test.sv
module flash_status_poller_test;

  localparam int ADDR_W  = 16;
  localparam int LIMIT_W = 8;

  typedef struct packed {
    logic [47:0] seq;       // byte 0 in bits [7:0]
    logic [7:0]  lim;
    logic        useRdy;
    logic        rdy;
    logic [3:0]  expReads;
    logic [3:0]  expFlags;  // {pass, fail, timeout, wdog}
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{48'h0000_0000_0000, 8'd20, 1'b0, 1'b0, 4'd2, 4'b1000}, // R4 stable pair
    '{48'h0000_4040_4000, 8'd20, 1'b0, 1'b0, 4'd4, 4'b1000}, // R5 loop then stable
    '{48'h0000_0060_6000, 8'd20, 1'b0, 1'b0, 4'd3, 4'b1000}, // R6 confirm settles
    '{48'h0000_0020_6000, 8'd20, 1'b0, 1'b0, 4'd3, 4'b0110}, // R7 confirm toggles
    '{48'h0000_4000_4000, 8'd3,  1'b0, 1'b0, 4'd3, 4'b0101}, // R9 budget on first of pair
    '{48'h0000_0000_4000, 8'd20, 1'b1, 1'b1, 4'd1, 4'b1000}, // R8 pin ends poll
    '{48'h0000_0000_4000, 8'd20, 1'b0, 1'b1, 4'd4, 4'b1000}, // R8 pin disabled
    '{48'h0000_0000_6000, 8'd2,  1'b0, 1'b0, 4'd2, 4'b0101}, // R9 budget beats confirm
    '{48'h0000_0000_0000, 8'd2,  1'b0, 1'b0, 4'd2, 4'b1000}  // R9 pass wins at limit
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [ADDR_W-1:0] targetAddr = '0;
  logic useRdyPin = 1'b0;
  logic rdyBusyN = 1'b0;
  logic [LIMIT_W-1:0] pollLimit = 8'd20;
  logic memReq;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memRdata = 8'h00;
  logic memValid = 1'b0;
  logic donePulse, busy, passFlag, failFlag, timeoutFlag, wdogFlag;

  int checks = 0;
  int fails = 0;
  logic [47:0] curSeq = '0;
  int idx = 0;
  int lat = 0;
  int waitCnt = 0;
  int readCnt = 0;
  int addrErr = 0;
  int dropErr = 0;
  int doneCnt = 0;
  logic prevPending = 1'b0;
  logic [ADDR_W-1:0] expAddr = '0;

  flash_status_poller #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .targetAddr(targetAddr),
    .useRdyPin(useRdyPin), .rdyBusyN(rdyBusyN), .pollLimit(pollLimit),
    .memReq(memReq), .memAddr(memAddr), .memRdata(memRdata), .memValid(memValid),
    .donePulse(donePulse), .busy(busy), .passFlag(passFlag), .failFlag(failFlag),
    .timeoutFlag(timeoutFlag), .wdogFlag(wdogFlag)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rstN && donePulse) doneCnt++;

  // Memory responder: acts on falling edges only
  always @(negedge clk) begin
    if (prevPending && !memReq) dropErr++;
    if (!rstN) begin
      memValid = 1'b0;
      waitCnt  = 0;
    end else if (memValid) begin
      memValid = 1'b0;
      idx++;
    end else if (memReq) begin
      if (waitCnt >= lat) begin
        memValid = 1'b1;
        memRdata = (idx < 6) ? curSeq[8*idx +: 8] : 8'h00;
        readCnt++;
        if (memAddr !== expAddr) addrErr++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end
    prevPending = memReq && !memValid;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startPoll(input logic [47:0] s, input int latency, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    curSeq = s; idx = 0; lat = latency; waitCnt = 0; readCnt = 0; doneCnt = 0;
    expAddr = a; targetAddr = a; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400 && !ok; k++) begin
      @(negedge clk);
      if (donePulse) ok = 1'b1;
    end
  endtask

  function automatic logic [3:0] flagsNow();
    return {passFlag, failFlag, timeoutFlag, wdogFlag};
  endfunction

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 memReq", memReq, 0);
    check("R1 done", donePulse, 0);
    check("R1 flags", flagsNow(), 4'b0000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      useRdyPin = VECS[v].useRdy;
      rdyBusyN  = VECS[v].rdy;
      pollLimit = VECS[v].lim;
      repeat (4) @(negedge clk);
      startPoll(VECS[v].seq, v % 3, ADDR_W'(16'h1000 + v * 16'h0111));
      waitDone(ok);
      check($sformatf("R10 vec%0d done seen", v), ok, 1);
      check($sformatf("R4-R9 vec%0d flags", v), flagsNow(), VECS[v].expFlags);
      check($sformatf("R5 vec%0d read count", v), readCnt, VECS[v].expReads);
      @(negedge clk);
      check($sformatf("R10 vec%0d pulse width", v), donePulse, 0);
      check($sformatf("R10 vec%0d idle after", v), busy, 0);
    end
    check("R2 address per read", addrErr, 0);
    check("R3 request held", dropErr, 0);

    // R10 flags held, then cleared by next start
    useRdyPin = 1'b0; rdyBusyN = 1'b0; pollLimit = 8'd20;
    startPoll(48'h0000_0020_6000, 1, 16'h2222);
    waitDone(ok);
    repeat (10) @(negedge clk);
    check("R10 fail held", flagsNow(), 4'b0110);
    startPoll(48'h0000_0000_0000, 2, 16'h3333);
    check("R10 flags cleared at start", flagsNow(), 4'b0000);
    waitDone(ok);
    check("R10 pass after clear", flagsNow(), 4'b1000);

    // R2 start while busy is ignored
    repeat (3) @(negedge clk);
    startPoll(48'h4040_0040_0040, 3, 16'h0ABC);
    repeat (4) @(negedge clk);
    targetAddr = 16'h0DEF; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    waitDone(ok);
    check("R2 busy-start poll ends", ok, 1);
    check("R2 busy-start flags", flagsNow(), 4'b1000);
    check("R2 busy-start reads", readCnt, 6);
    check("R2 busy-start address", addrErr, 0);
    repeat (20) @(negedge clk);
    check("R2 single done", doneCnt, 1);
    check("R2 idle after", busy, 0);
    check("R3 request held slow", dropErr, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule